// File: doc/BRIEF.md
# SMBus Configuration Write Sequencer

This block is the transaction layer of an SMBus slave that turns a run of short SMBus writes into one internal register-write request. A bus front end handles the bit timing and hands over a byte stream: a start pulse, a stop pulse, and one valid pulse per received byte. The first byte after a start is the address byte with its R/W bit. For each byte the sequencer returns an acknowledge decision, one cycle later for all bytes except the closing one.

Every SMBus write carries a command byte, then a short payload. Flags in the command byte open the sequence, close it, and turn on packet error checking. A low-nibble code in the same byte picks one of two forms. In the word form each write carries two payload bytes. In the byte form each write carries one. The eight payload bytes, in arrival order, are the bus number, the device/function, the register number (high byte first) and the 32-bit data (most significant byte first). When the closing write is accepted, the block issues one request pulse downstream. It then holds that write's final acknowledge until the downstream access reports done, and turns it into a NAK if the access reported an error.

Top module: `smb_cfgwr_seq`

## Requirements
- R1: The address byte is acknowledged only if it equals {2'b11, addr_strap[3], 1'b0, addr_strap[2:0], 1'b0}, which is a write to the strapped address. Any other address byte is NAKed, and every later byte up to the next start or stop is NAKed.
- R2: Command byte fields are: bit 7 opens a sequence, bit 6 closes it, bit 4 enables packet error checking, and bit 5 must be 0. A low nibble of 4'hD selects the two-byte form and 4'hC the one-byte form. Any other command byte is NAKed and the open sequence is discarded.
- R3: The request carries the payload bytes in arrival order: byte 1 on req_bus, byte 2 on req_devfn, bytes 3 and 4 on req_reg (high byte first), and bytes 5 to 8 on req_data (most significant byte first).
- R4: A command without the open flag, received while no sequence is open, is NAKed at the command byte.
- R5: A command is NAKed, and the sequence discarded, in three cases: it would take the payload past 8 bytes, it closes the sequence at a total other than 8, or it uses a different form from the open sequence.
- R6: With checking enabled, a check byte follows the payload. Its value is the CRC-8 (polynomial 0x07, initial value 0x00, MSB first) over the address, command and payload bytes. A matching check byte is ACKed. A mismatch is NAKed and discards the sequence.
- R7: One single-cycle req_vld pulse is issued only after the final byte of the closing write is accepted. That byte's acknowledge is held until cfg_done, then returned one cycle later as ACK if cfg_err is 0 and NAK if it is 1.
- R8: A stop or a repeated start in the middle of a write's payload or check byte discards the open sequence.
- R9: Every byte other than the final byte of a closing write gets ack_vld exactly one cycle after its byte_valid. The block raises ack_vld only in response to a byte or a cfg_done.
- R10: After reset no sequence is open, and ack_vld and req_vld are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 4 | Strapped bits of the slave address |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| bus_stop | input | 1 | Stop seen on the bus |
| byte_valid | input | 1 | One received byte on byte_data |
| byte_data | input | 8 | Received byte |
| ack_vld | output | 1 | Acknowledge decision is valid |
| ack_ok | output | 1 | 1 = ACK, 0 = NAK |
| req_vld | output | 1 | Single-cycle configuration write request |
| req_bus | output | 8 | Bus number |
| req_devfn | output | 8 | Device/function |
| req_reg | output | 16 | Register number |
| req_data | output | 32 | Write data |
| cfg_done | input | 1 | Downstream access finished |
| cfg_err | input | 1 | Downstream access failed (valid with cfg_done) |

## Verification
The bench drives full sequences in both forms, with and without check bytes, and with a downstream responder that adds a delay and can return an error. A design that acknowledged the closing byte before cfg_done, or ignored cfg_err, would show the wrong hold time or an ACK where a NAK is due. The bench also sends a command with no open flag, a fifth word write, a close after only four payload bytes, a form switch, a corrupted mid-sequence check byte, and a stop inside a payload. It then confirms that the next write without the open flag is NAKed. A design that kept stale state would ACK those follow-up commands, and one that packed the payload in the wrong order would give a mismatched request.

// File: rtl/smb_cfgwr_pkg.sv
package smb_cfgwr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_DATA,
      ST_PEC,
      ST_WAIT,
      ST_SKIP
   } seq_st_e;

   typedef struct packed {
      logic open_f;
      logic close_f;
      logic pec_f;
      logic word_f;
      logic fmt_ok;
   } cmd_info_t;

   // bitwise CRC step, feeding data MSB first
   function automatic logic [7:0] pec_step(logic [7:0] cur, logic [7:0] din, logic [7:0] poly);
      logic [7:0] r;
      logic       fb;
      r = cur;
      for (int i = 7; i >= 0; i--) begin
         fb = r[7] ^ din[i];
         r  = {r[6:0], 1'b0} ^ (fb ? poly : 8'h00);
      end
      return r;
   endfunction

endpackage

// File: rtl/smb_cmd_dec.sv
module smb_cmd_dec
   import smb_cfgwr_pkg::*;
#(
   parameter logic [3:0] WORD_CODE = 4'hD,
   parameter logic [3:0] BYTE_CODE = 4'hC,
   parameter bit         PEC_ON    = 1'b1
) (
   input  logic [7:0] cmd_byte,
   output cmd_info_t  info
);

   logic is_word;
   logic is_byte;

   always_comb begin
      is_word      = (cmd_byte[3:0] == WORD_CODE);
      is_byte      = (cmd_byte[3:0] == BYTE_CODE);
      info.open_f  = cmd_byte[7];
      info.close_f = cmd_byte[6];
      info.pec_f   = cmd_byte[4];
      info.word_f  = is_word;
      info.fmt_ok  = !cmd_byte[5] && (is_word || is_byte) && (PEC_ON || !cmd_byte[4]);
   end

endmodule

// File: rtl/smb_pec_acc.sv
module smb_pec_acc
   import smb_cfgwr_pkg::*;
#(
   parameter logic [7:0] POLY   = 8'h07,
   parameter logic [7:0] INIT   = 8'h00,
   parameter bit         PEC_ON = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       upd,
   input  logic [7:0] din,
   output logic [7:0] crc
);

   generate
      if (PEC_ON) begin : g_pec
         logic [7:0] crc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               crc_q <= INIT;
            else if (clr)
               crc_q <= INIT;
            else if (upd)
               crc_q <= pec_step(crc_q, din, POLY);
         end
         assign crc = crc_q;
      end else begin : g_nopec
         logic unused_pins;
         assign unused_pins = ^{clk, rst_n, clr, upd, din};
         assign crc = INIT;
      end
   endgenerate

endmodule

// File: rtl/smb_cfg_buf.sv
module smb_cfg_buf #(
   parameter int BYTE_W = 8,
   parameter int NBYTES = 8,
   localparam int PTR_W = $clog2(NBYTES + 1),
   localparam int TOT_W = NBYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [PTR_W-1:0]  wptr,
   input  logic [BYTE_W-1:0] din,
   output logic [TOT_W-1:0]  flat
);

   // slot 0 lands in the most significant byte of flat
   for (genvar i = 0; i < NBYTES; i++) begin : g_slot
      localparam logic [PTR_W-1:0] IDX = PTR_W'(i);
      logic [BYTE_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr && wptr == IDX)
            slot_q <= din;
      end
      assign flat[(NBYTES-1-i)*BYTE_W +: BYTE_W] = slot_q;
   end

endmodule

// File: rtl/smb_cfgwr_seq.sv
module smb_cfgwr_seq
   import smb_cfgwr_pkg::*;
#(
   parameter int         BYTE_W    = 8,
   parameter int         REG_W     = 16,
   parameter int         DATA_W    = 32,
   parameter logic [3:0] WORD_CODE = 4'hD,
   parameter logic [3:0] BYTE_CODE = 4'hC,
   parameter logic [7:0] PEC_POLY  = 8'h07,
   parameter logic [7:0] PEC_INIT  = 8'h00,
   parameter bit         PEC_ON    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        addr_strap,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              ack_vld,
   output logic              ack_ok,
   output logic              req_vld,
   output logic [BYTE_W-1:0] req_bus,
   output logic [BYTE_W-1:0] req_devfn,
   output logic [REG_W-1:0]  req_reg,
   output logic [DATA_W-1:0] req_data,
   input  logic              cfg_done,
   input  logic              cfg_err
);

   localparam int TOT_W  = 2 * BYTE_W + REG_W + DATA_W;
   localparam int NBYTES = TOT_W / BYTE_W;
   localparam int PTR_W  = $clog2(NBYTES + 1);
   localparam logic [PTR_W:0]   FULL_CNT = (PTR_W + 1)'(NBYTES);
   localparam logic [PTR_W-1:0] ONE      = PTR_W'(1);
   localparam logic [PTR_W-1:0] TWO      = PTR_W'(2);

   // elaboration-time parameter checks
   if (BYTE_W != 8) begin : g_bad_byte_w
      $error("BYTE_W must be 8: command and check fields are byte wide");
   end
   if ((REG_W % BYTE_W) != 0 || (DATA_W % BYTE_W) != 0) begin : g_bad_fields
      $error("REG_W and DATA_W must be whole bytes");
   end
   if ((NBYTES % 2) != 0) begin : g_bad_count
      $error("payload must be an even byte count for the two-byte form");
   end

   seq_st_e          state_q;
   logic             open_q;
   logic             word_q;
   logic             pec_q;
   logic             close_q;
   logic [PTR_W-1:0] wptr_q;
   logic [PTR_W-1:0] rem_q;

   cmd_info_t        info;
   logic             addr_hit;
   logic [PTR_W-1:0] base_ptr;
   logic [PTR_W-1:0] per_txn;
   logic [PTR_W:0]   new_cnt;
   logic             cmd_legal;
   logic [7:0]       crc;
   logic             crc_clr;
   logic             crc_upd;
   logic             buf_wr;
   logic [TOT_W-1:0] flat;
   logic             in_payload;
   logic             bus_edge;

   smb_cmd_dec #(
      .WORD_CODE (WORD_CODE),
      .BYTE_CODE (BYTE_CODE),
      .PEC_ON    (PEC_ON)
   ) u_dec (
      .cmd_byte (byte_data),
      .info     (info)
   );

   smb_pec_acc #(
      .POLY   (PEC_POLY),
      .INIT   (PEC_INIT),
      .PEC_ON (PEC_ON)
   ) u_pec (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .upd   (crc_upd),
      .din   (byte_data),
      .crc   (crc)
   );

   smb_cfg_buf #(
      .BYTE_W (BYTE_W),
      .NBYTES (NBYTES)
   ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (buf_wr),
      .wptr  (wptr_q),
      .din   (byte_data),
      .flat  (flat)
   );

   always_comb begin
      addr_hit   = (byte_data == {2'b11, addr_strap[3], 1'b0, addr_strap[2:0], 1'b0});
      base_ptr   = info.open_f ? '0 : wptr_q;
      per_txn    = info.word_f ? TWO : ONE;
      new_cnt    = {1'b0, base_ptr} + {1'b0, per_txn};
      cmd_legal  = info.fmt_ok
                && (info.open_f || (open_q && (info.word_f == word_q)))
                && (new_cnt <= FULL_CNT)
                && (!info.close_f || new_cnt == FULL_CNT);
      in_payload = (state_q == ST_DATA) || (state_q == ST_PEC);
      bus_edge   = (state_q != ST_WAIT) && (bus_start || bus_stop);
      crc_clr    = bus_start && (state_q != ST_WAIT);
      crc_upd    = byte_valid && !bus_edge
                && (state_q == ST_ADDR || state_q == ST_CMD || state_q == ST_DATA);
      buf_wr     = byte_valid && !bus_edge && (state_q == ST_DATA);
   end

   assign req_bus   = flat[TOT_W-1 -: BYTE_W];
   assign req_devfn = flat[TOT_W-BYTE_W-1 -: BYTE_W];
   assign req_reg   = flat[DATA_W +: REG_W];
   assign req_data  = flat[0 +: DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         open_q  <= 1'b0;
         word_q  <= 1'b0;
         pec_q   <= 1'b0;
         close_q <= 1'b0;
         wptr_q  <= '0;
         rem_q   <= '0;
         ack_vld <= 1'b0;
         ack_ok  <= 1'b0;
         req_vld <= 1'b0;
      end else begin
         ack_vld <= 1'b0;
         req_vld <= 1'b0;
         if (bus_edge) begin
            if (in_payload)
               open_q <= 1'b0;
            state_q <= bus_start ? ST_ADDR : ST_IDLE;
         end else begin
            unique case (state_q)
               ST_ADDR: if (byte_valid) begin
                  ack_vld <= 1'b1;
                  ack_ok  <= addr_hit;
                  state_q <= addr_hit ? ST_CMD : ST_SKIP;
               end
               ST_CMD: if (byte_valid) begin
                  ack_vld <= 1'b1;
                  ack_ok  <= cmd_legal;
                  if (cmd_legal) begin
                     open_q  <= 1'b1;
                     word_q  <= info.word_f;
                     pec_q   <= info.pec_f;
                     close_q <= info.close_f;
                     wptr_q  <= base_ptr;
                     rem_q   <= per_txn;
                     state_q <= ST_DATA;
                  end else begin
                     open_q  <= 1'b0;
                     state_q <= ST_SKIP;
                  end
               end
               ST_DATA: if (byte_valid) begin
                  wptr_q <= wptr_q + ONE;
                  rem_q  <= rem_q - ONE;
                  if (rem_q != ONE) begin
                     ack_vld <= 1'b1;
                     ack_ok  <= 1'b1;
                  end else if (pec_q) begin
                     ack_vld <= 1'b1;
                     ack_ok  <= 1'b1;
                     state_q <= ST_PEC;
                  end else if (close_q) begin
                     req_vld <= 1'b1;
                     state_q <= ST_WAIT;
                  end else begin
                     ack_vld <= 1'b1;
                     ack_ok  <= 1'b1;
                     state_q <= ST_SKIP;
                  end
               end
               ST_PEC: if (byte_valid) begin
                  if (byte_data != crc) begin
                     ack_vld <= 1'b1;
                     ack_ok  <= 1'b0;
                     open_q  <= 1'b0;
                     state_q <= ST_SKIP;
                  end else if (close_q) begin
                     req_vld <= 1'b1;
                     state_q <= ST_WAIT;
                  end else begin
                     ack_vld <= 1'b1;
                     ack_ok  <= 1'b1;
                     state_q <= ST_SKIP;
                  end
               end
               ST_WAIT: if (cfg_done) begin
                  ack_vld <= 1'b1;
                  ack_ok  <= !cfg_err;
                  open_q  <= 1'b0;
                  state_q <= ST_SKIP;
               end
               default: if (byte_valid) begin
                  ack_vld <= 1'b1;
                  ack_ok  <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/smb_cfgwr_chk.sv
module smb_cfgwr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_start,
   input logic       byte_valid,
   input logic [7:0] byte_data,
   input logic       ack_vld,
   input logic       ack_ok,
   input logic       req_vld,
   input logic       cfg_done,
   input logic       cfg_err
);

   logic pend_q;
   logic addr_ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         addr_ph_q <= 1'b0;
      end else begin
         if (req_vld)
            pend_q <= 1'b1;
         else if (cfg_done)
            pend_q <= 1'b0;
         if (bus_start)
            addr_ph_q <= 1'b1;
         else if (byte_valid)
            addr_ph_q <= 1'b0;
      end
   end

   // R7
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> !req_vld);

   // R7
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld || (pend_q && !cfg_done)) |=> !ack_vld);

   // R7
   err_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && cfg_done && cfg_err) |=> (ack_vld && !ack_ok));

   // R7
   req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |-> $past(byte_valid));

   // R9
   ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> ($past(byte_valid) || $past(cfg_done)));

   // R9
   ack_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !pend_q && !req_vld && !bus_start) |=> (ack_vld || req_vld));

   // R1
   addr_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_ph_q && byte_valid && !bus_start && byte_data[7:6] != 2'b11) |=> (ack_vld && !ack_ok));

endmodule

bind smb_cfgwr_seq smb_cfgwr_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_start  (bus_start),
   .byte_valid (byte_valid),
   .byte_data  (byte_data),
   .ack_vld    (ack_vld),
   .ack_ok     (ack_ok),
   .req_vld    (req_vld),
   .cfg_done   (cfg_done),
   .cfg_err    (cfg_err)
);

// File: tb/smb_cfgwr_seq_test.sv
`timescale 1ns/1ps
module smb_cfgwr_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr_strap = 4'b1010;
   logic        bus_start = 1'b0;
   logic        bus_stop = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic        ack_vld, ack_ok, req_vld;
   logic [7:0]  req_bus, req_devfn;
   logic [15:0] req_reg;
   logic [31:0] req_data;
   logic        cfg_done = 1'b0;
   logic        cfg_err = 1'b0;

   // strap 1010 -> address 7'b1110010, write -> 0xE4
   localparam logic [7:0] MY_ADDR = 8'hE4;

   always #2.5 clk = ~clk;

   smb_cfgwr_seq uut (
      .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
      .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .ack_vld(ack_vld), .ack_ok(ack_ok),
      .req_vld(req_vld), .req_bus(req_bus), .req_devfn(req_devfn),
      .req_reg(req_reg), .req_data(req_data),
      .cfg_done(cfg_done), .cfg_err(cfg_err)
   );

   int          checks = 0;
   int          errors = 0;
   int          acks_seen = 0;
   int          ds_delay = 3;
   bit          ds_err = 1'b0;
   bit          exp_ack_q[$];
   string       ack_tag_q[$];
   logic [63:0] exp_req_q[$];
   bit          mon_e;
   string       mon_t;
   logic [63:0] mon_r;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_next(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      r = c ^ d;
      for (int k = 0; k < 8; k++)
         r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
      return r;
   endfunction

   // monitor: pops expected items as the design produces results
   always @(negedge clk) begin
      if (rst_n) begin
         if (ack_vld) begin
            if (exp_ack_q.size() == 0)
               chk(1'b0, "R9", "unexpected ack", 64'(ack_ok), 64'h0);
            else begin
               mon_e = exp_ack_q.pop_front();
               mon_t = ack_tag_q.pop_front();
               chk(ack_ok == mon_e, mon_t, "ack", 64'(ack_ok), 64'(mon_e));
            end
            acks_seen++;
         end
         if (req_vld) begin
            if (exp_req_q.size() == 0)
               chk(1'b0, "R7", "unexpected request", {req_bus, req_devfn, req_reg, req_data}, 64'h0);
            else begin
               mon_r = exp_req_q.pop_front();
               chk({req_bus, req_devfn, req_reg, req_data} == mon_r, "R3", "request fields",
                   {req_bus, req_devfn, req_reg, req_data}, mon_r);
            end
         end
      end
   end

   // downstream responder
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && req_vld) begin
            repeat (ds_delay) @(negedge clk);
            cfg_done = 1'b1;
            cfg_err  = ds_err;
            @(negedge clk);
            cfg_done = 1'b0;
            cfg_err  = 1'b0;
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); #1; bus_start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); #1; bus_stop = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp, input string tag, input bit held);
      int n0;
      int cyc;
      n0 = acks_seen;
      exp_ack_q.push_back(exp);
      ack_tag_q.push_back(tag);
      @(negedge clk); byte_valid = 1'b1; byte_data = b;
      @(negedge clk); #1; byte_valid = 1'b0;
      cyc = 1;
      while (acks_seen == n0) begin
         @(negedge clk); #1;
         cyc++;
      end
      if (held) chk(cyc == ds_delay + 2, "R7", "ack hold cycles", 64'(cyc), 64'(ds_delay + 2));
      else      chk(cyc == 1, "R9", "ack latency", 64'(cyc), 64'h1);
   endtask

   // one SMBus write: address, command, n payload bytes, optional check byte
   task automatic txn(input logic [7:0] cmd, input logic [7:0] p0, input logic [7:0] p1,
                      input int n, input bit cmd_ok, input bit corrupt,
                      input bit held, input bit last_ok, input string tag);
      logic [7:0] c;
      logic [7:0] b;
      bit         last;
      c = 8'h00;
      pulse_start();
      send_byte(MY_ADDR, 1'b1, "R1", 1'b0);
      c = crc_next(c, MY_ADDR);
      send_byte(cmd, cmd_ok, tag, 1'b0);
      c = crc_next(c, cmd);
      if (!cmd_ok) begin
         send_byte(p0, 1'b0, tag, 1'b0);
         pulse_stop();
         return;
      end
      for (int i = 0; i < n; i++) begin
         b = (i == 0) ? p0 : p1;
         last = (i == n - 1) && !cmd[4];
         if (last) send_byte(b, last_ok, tag, held);
         else      send_byte(b, 1'b1, tag, 1'b0);
         c = crc_next(c, b);
      end
      if (cmd[4])
         send_byte(corrupt ? (c ^ 8'h01) : c, last_ok, tag, held);
      pulse_stop();
   endtask

   task automatic word_write(input logic [63:0] v, input bit pec, input bit err, input string tag);
      logic [7:0] pb;
      pb = pec ? 8'h10 : 8'h00;
      ds_err = err;
      exp_req_q.push_back(v);
      txn(8'h8D | pb, v[63:56], v[55:48], 2, 1'b1, 1'b0, 1'b0, 1'b1, tag);
      txn(8'h0D | pb, v[47:40], v[39:32], 2, 1'b1, 1'b0, 1'b0, 1'b1, tag);
      txn(8'h0D | pb, v[31:24], v[23:16], 2, 1'b1, 1'b0, 1'b0, 1'b1, tag);
      txn(8'h4D | pb, v[15:8],  v[7:0],   2, 1'b1, 1'b0, 1'b1, !err, tag);
   endtask

   task automatic byte_write(input logic [63:0] v, input bit pec, input bit err, input string tag);
      logic [7:0] cmd;
      ds_err = err;
      exp_req_q.push_back(v);
      for (int k = 0; k < 8; k++) begin
         cmd = 8'h0C | (pec ? 8'h10 : 8'h00) | ((k == 0) ? 8'h80 : 8'h00) | ((k == 7) ? 8'h40 : 8'h00);
         txn(cmd, v[63-8*k -: 8], 8'h00, 1, 1'b1, 1'b0, (k == 7), (k == 7) ? !err : 1'b1, tag);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(ack_vld == 1'b0, "R10", "ack_vld in reset", 64'(ack_vld), 64'h0);
      chk(req_vld == 1'b0, "R10", "req_vld in reset", 64'(req_vld), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10: nothing is open after reset
      txn(8'h0D, 8'h11, 8'h22, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R10");

      // R3 / R2: word form, no check byte
      ds_delay = 3;
      word_write(64'h01_2A_0F_5C_DEADBEEF, 1'b0, 1'b0, "R3");

      // R6 / R7: word form with check byte, downstream error
      word_write(64'h7F_08_00_40_12345678, 1'b1, 1'b1, "R7");

      // R2: byte form with check byte
      ds_delay = 1;
      byte_write(64'hA5_3C_81_02_CAFEF00D, 1'b1, 1'b0, "R2");

      // R1: wrong strap bits and read direction
      pulse_start();
      send_byte(8'hE6, 1'b0, "R1", 1'b0);
      send_byte(8'h8D, 1'b0, "R1", 1'b0);
      pulse_stop();
      pulse_start();
      send_byte(8'hE5, 1'b0, "R1", 1'b0);
      pulse_stop();

      // R4: no open flag with nothing open
      txn(8'h0D, 8'h01, 8'h02, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R4");

      // R6: bad check byte mid-sequence discards the sequence
      txn(8'h9D, 8'h01, 8'h02, 2, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
      txn(8'h1D, 8'h03, 8'h04, 2, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
      txn(8'h1D, 8'h05, 8'h06, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R6");

      // R5: overflow past 8 bytes
      txn(8'h8D, 8'h01, 8'h02, 2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      txn(8'h0D, 8'h03, 8'h04, 2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      txn(8'h0D, 8'h05, 8'h06, 2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      txn(8'h0D, 8'h07, 8'h08, 2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      txn(8'h0D, 8'h09, 8'h0A, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
      // R5: close at the wrong count
      txn(8'h8D, 8'h01, 8'h02, 2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      txn(8'h4D, 8'h03, 8'h04, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
      // R5: form switch inside a sequence
      txn(8'h8D, 8'h01, 8'h02, 2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
      txn(8'h0C, 8'h03, 8'h00, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");

      // R2: unknown low nibble, reserved bit set
      txn(8'h8E, 8'h01, 8'h02, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
      txn(8'hAD, 8'h01, 8'h02, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R2");

      // R8: stop inside a payload discards the sequence
      pulse_start();
      send_byte(MY_ADDR, 1'b1, "R8", 1'b0);
      send_byte(8'h8D, 1'b1, "R8", 1'b0);
      send_byte(8'h33, 1'b1, "R8", 1'b0);
      pulse_stop();
      txn(8'h0D, 8'h44, 8'h55, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R8");

      // recovery: a clean sequence still completes
      ds_delay = 5;
      word_write(64'h00_F8_01_FC_0BADC0DE, 1'b1, 1'b0, "R7");

      repeat (4) @(negedge clk);
      chk(exp_ack_q.size() == 0, "R9", "acks left unanswered", 64'(exp_ack_q.size()), 64'h0);
      chk(exp_req_q.size() == 0, "R7", "requests never issued", 64'(exp_req_q.size()), 64'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule